// File: doc/BRIEF.md
# ADC Scan Sequencer with Register-File Store

This block walks a group of analog inputs in rising order, asks an external converter for one conversion on each, and stores every 10-bit result as two bytes in a register-file buffer. Software sets two registers through a small write port. The first register is the upper destination address. The second register holds the run enable, the interrupt enable and the number of the highest input to convert. A scan request pulse then starts a pass. The pass always begins at input 0 and ends at the programmed highest input.

For each input, the sequencer pulses a start to the converter with the input number on a select bus. It waits for the converter's done pulse and latches the result. It then writes the upper byte and the lower byte on two consecutive cycles. Only after both bytes are stored does it move to the next input. When the last input has been stored, an interrupt pulse marks the end of the scan if interrupts are enabled. If software clears the enable during a scan, the sequencer completes any byte pair already started and then stops quietly. A mode output tells the converter whether it must run single-shot, which is the case whenever more than one input is scanned.

Top module: `adc_scan_dma`

## Requirements
- R1: After reset, both registers are zero, and adcStart, memWe and irq are low.
- R2: While the enable bit is 0, a scanReq pulse causes no converter start and no memory write.
- R3: A scan issues exactly one adcStart pulse per input, with adcSel taking the values 0, 1, ..., N in order, where N is the input-count field.
- R4: With the input-count field at 0, a scan converts and stores only input 0.
- R5: No adcStart is issued until the done of the previous start has been received and both bytes of its result have been written.
- R6: The result for input k is written at address {base, k, b}, with b=0 for the upper byte and b=1 for the lower byte one cycle later.
- R7: The upper byte carries result bits 9:8 in its low two bits with zeros above them, and the lower byte carries result bits 7:0.
- R8: One cycle after the last lower-byte write, irq is high for exactly one cycle if the interrupt enable is set; otherwise irq stays low.
- R9: Clearing the enable during a scan lets the byte pair in progress complete, then issues no further start and no interrupt.
- R10: adcSingleShot is high exactly when the input-count field is non-zero.
- R11: Register writes use regSel=0 for the base (regWdata[6:0]) and regSel=1 for control (bit 0 enable, bit 1 interrupt enable, bits 4:2 input count).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 base, 1 control |
| regWdata | input | 8 | Register write data |
| scanReq | input | 1 | Request to begin a scan |
| adcStart | output | 1 | One-cycle conversion start to the converter |
| adcSel | output | 3 | Input number being converted |
| adcSingleShot | output | 1 | Converter must use single-shot mode |
| adcDone | input | 1 | Conversion finished pulse |
| adcResult | input | 10 | Conversion result, valid with adcDone |
| memWe | output | 1 | Register-file write strobe |
| memAddr | output | 11 | Register-file write address |
| memData | output | 8 | Register-file write data |
| irq | output | 1 | End-of-scan interrupt pulse |

## Verification
The bench uses the default parameters: 7 base bits, a 3-bit input count, 10-bit results and 8-bit bytes. These are small enough to sweep every input count from 0 to 7 against both interrupt settings and three base addresses, including the all-ones base that fills the top address bits. The converter model varies its latency per input and derives each result from the input number and a per-scan seed. This makes every stored byte and address predictable by arithmetic. Separate runs cover the disabled request and an abort that clears the enable in the middle of a byte pair.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // control register field positions
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_IRQ_BIT = 1;
  localparam int CTL_CNT_LSB = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_WAIT,
    S_WRHI,
    S_WRLO,
    S_DONE
  } scanState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCh;
    logic incCh;
    logic capture;
    logic wrEn;
    logic byteLo;
  } scanStrobe_t;

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        scanReq,
  input  logic        en,
  input  logic        irqEn,
  input  logic        lastCh,
  input  logic        adcDone,
  output scanStrobe_t strb,
  output logic        adcStart,
  output logic        irq
);

  scanState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    adcStart = 1'b0;
    irq      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (en && scanReq) begin
          strb.clrCh = 1'b1;
          stateNxt   = S_START;
        end
      end
      S_START: begin
        adcStart = en;
        stateNxt = en ? S_WAIT : S_IDLE;
      end
      S_WAIT: begin
        if (!en) begin
          stateNxt = S_IDLE;
        end else if (adcDone) begin
          strb.capture = 1'b1;
          stateNxt     = S_WRHI;
        end
      end
      S_WRHI: begin
        strb.wrEn = 1'b1;
        stateNxt  = S_WRLO;
      end
      S_WRLO: begin
        strb.wrEn   = 1'b1;
        strb.byteLo = 1'b1;
        if (!en) begin
          stateNxt = S_IDLE;
        end else if (lastCh) begin
          stateNxt = S_DONE;
        end else begin
          strb.incCh = 1'b1;
          stateNxt   = S_START;
        end
      end
      S_DONE: begin
        irq      = irqEn;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/adc_scan_dpath.sv
module adc_scan_dpath
  import adc_scan_pkg::*;
#(
  parameter int BASE_W = 7,
  parameter int CNT_W  = 3,
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  localparam int ADDR_W = BASE_W + CNT_W + 1,
  localparam int HI_W   = RES_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  scanStrobe_t       strb,
  input  logic [RES_W-1:0]  adcResult,
  output logic              en,
  output logic              irqEn,
  output logic              lastCh,
  output logic [CNT_W-1:0]  adcSel,
  output logic              adcSingleShot,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  logic [BASE_W-1:0] baseReg;
  logic [CNT_W-1:0]  cntReg;
  logic [CNT_W-1:0]  chReg;
  logic [RES_W-1:0]  resReg;
  logic              enReg;
  logic              irqEnReg;
  logic [DATA_W-1:0] hiByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      cntReg   <= '0;
      enReg    <= 1'b0;
      irqEnReg <= 1'b0;
    end else if (regWe) begin
      if (!regSel) begin
        baseReg <= regWdata[BASE_W-1:0];
      end else begin
        enReg    <= regWdata[CTL_EN_BIT];
        irqEnReg <= regWdata[CTL_IRQ_BIT];
        cntReg   <= regWdata[CTL_CNT_LSB +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            chReg <= '0;
    else if (strb.clrCh)  chReg <= '0;
    else if (strb.incCh)  chReg <= chReg + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              resReg <= '0;
    else if (strb.capture)  resReg <= adcResult;
  end

  generate
    if (HI_W < DATA_W) begin : g_pad
      assign hiByte = {{(DATA_W - HI_W){1'b0}}, resReg[RES_W-1:DATA_W]};
    end else begin : g_full
      assign hiByte = resReg[RES_W-1 -: DATA_W];
    end
  endgenerate

  assign en            = enReg;
  assign irqEn         = irqEnReg;
  assign lastCh        = (chReg == cntReg);
  assign adcSel        = chReg;
  assign adcSingleShot = (cntReg != '0);
  assign memWe         = strb.wrEn;
  assign memAddr       = {baseReg, chReg, strb.byteLo};
  assign memData       = strb.byteLo ? resReg[DATA_W-1:0] : hiByte;

endmodule

// File: rtl/adc_scan_dma.sv
module adc_scan_dma
  import adc_scan_pkg::*;
#(
  parameter int BASE_W = 7,
  parameter int CNT_W  = 3,
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  localparam int ADDR_W = BASE_W + CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              scanReq,
  output logic              adcStart,
  output logic [CNT_W-1:0]  adcSel,
  output logic              adcSingleShot,
  input  logic              adcDone,
  input  logic [RES_W-1:0]  adcResult,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              irq
);

  scanStrobe_t strb;
  logic ctrlEn;
  logic ctrlIrqEn;
  logic lastCh;

  adc_scan_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .scanReq  (scanReq),
    .en       (ctrlEn),
    .irqEn    (ctrlIrqEn),
    .lastCh   (lastCh),
    .adcDone  (adcDone),
    .strb     (strb),
    .adcStart (adcStart),
    .irq      (irq)
  );

  adc_scan_dpath #(
    .BASE_W (BASE_W),
    .CNT_W  (CNT_W),
    .RES_W  (RES_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .regWe         (regWe),
    .regSel        (regSel),
    .regWdata      (regWdata),
    .strb          (strb),
    .adcResult     (adcResult),
    .en            (ctrlEn),
    .irqEn         (ctrlIrqEn),
    .lastCh        (lastCh),
    .adcSel        (adcSel),
    .adcSingleShot (adcSingleShot),
    .memWe         (memWe),
    .memAddr       (memAddr),
    .memData       (memData)
  );

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              adcStart,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              irq,
  input logic              ctrlEn
);

  // a conversion is outstanding from its start until its lower byte is stored
  logic pending;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         pending <= 1'b0;
    else if (adcStart)                 pending <= 1'b1;
    else if ((memWe && memAddr[0]) || !ctrlEn) pending <= 1'b0;
  end

  a_r5_no_start_while_pending: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> !pending);

  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  a_r6_low_byte_follows: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !memAddr[0]) |=>
      (memWe && memAddr[0] && memAddr[ADDR_W-1:1] == $past(memAddr[ADDR_W-1:1])));

  a_r8_irq_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  a_r8_irq_after_store: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(memWe && memAddr[0]));

  a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlEn && $past(!ctrlEn)) |-> !adcStart);

endmodule

bind adc_scan_dma adc_scan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .adcStart (adcStart),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .irq      (irq),
  .ctrlEn   (ctrlEn)
);

// File: tb/sim_adc_scan_dma.sv
module sim_adc_scan_dma;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regSel = 1'b0;
  logic [7:0]  regWdata = '0;
  logic        scanReq = 1'b0;
  logic        adcStart;
  logic [2:0]  adcSel;
  logic        adcSingleShot;
  logic        adcDone = 1'b0;
  logic [9:0]  adcResult = '0;
  logic        memWe;
  logic [10:0] memAddr;
  logic [7:0]  memData;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int seed   = 0;

  int nStart = 0;
  int nWr    = 0;
  int nIrq   = 0;
  int startSel [0:15];
  int wAddr [0:31];
  int wData [0:31];
  int busy = 0;
  int latchSel = 0;

  always #5 clk = ~clk;

  adc_scan_dma u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .scanReq(scanReq), .adcStart(adcStart), .adcSel(adcSel),
    .adcSingleShot(adcSingleShot), .adcDone(adcDone), .adcResult(adcResult),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .irq(irq)
  );

  function automatic int resOf(int sel, int sd);
    return (sel * 97 + sd * 13 + 5) % 1024;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model and monitor, both on the falling edge
  always @(negedge clk) begin
    adcDone <= 1'b0;
    if (busy > 0) begin
      busy = busy - 1;
      if (busy == 0) begin
        adcDone   <= 1'b1;
        adcResult <= 10'(resOf(latchSel, seed));
      end
    end
    if (rstN && adcStart) begin
      // R5: previous result fully stored before the next start
      if (nStart > 0) check(nWr == 2 * nStart, "R5 writes before start", nWr, 2 * nStart);
      if (nStart < 16) startSel[nStart] = int'(adcSel);
      nStart++;
      latchSel = int'(adcSel);
      busy = 1 + ((latchSel + seed) % 4);
    end
    if (rstN && memWe) begin
      if (nWr < 32) begin
        wAddr[nWr] = int'(memAddr);
        wData[nWr] = int'(memData);
      end
      nWr++;
    end
    if (rstN && irq) nIrq++;
  end

  task automatic writeReg(bit sel, int data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = 8'(data);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk);
    scanReq = 1'b1;
    @(negedge clk);
    scanReq = 1'b0;
  endtask

  task automatic clearLog();
    nStart = 0; nWr = 0; nIrq = 0;
  endtask

  task automatic runScan(int base, int cnt, int ie, int sd);
    seed = sd;
    writeReg(1'b0, base);
    writeReg(1'b1, (cnt << 2) | (ie << 1) | 1);
    check(adcSingleShot == (cnt != 0), "R10 single-shot mode", int'(adcSingleShot), int'(cnt != 0));
    clearLog();
    pulseReq();
    repeat ((cnt + 1) * 10 + 10) @(negedge clk);
    check(nStart == cnt + 1, cnt == 0 ? "R4 one start" : "R3 start count", nStart, cnt + 1);
    for (int k = 0; k <= cnt && k < nStart; k++)
      check(startSel[k] == k, "R3 ascending select", startSel[k], k);
    check(nWr == 2 * (cnt + 1), "R6 write count", nWr, 2 * (cnt + 1));
    for (int i = 0; i < nWr && i < 2 * (cnt + 1); i++) begin
      int ch = i / 2;
      int r  = resOf(ch, sd);
      int ea = (base << 4) | (ch << 1) | (i % 2);
      int ed = (i % 2 == 1) ? (r % 256) : (r / 256);
      check(wAddr[i] == ea, "R6 address", wAddr[i], ea);
      check(wData[i] == ed, "R7 byte data", wData[i], ed);
    end
    check(nIrq == ie, "R8 interrupt count", nIrq, ie);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(adcStart == 1'b0, "R1 adcStart low", int'(adcStart), 0);
    check(memWe == 1'b0, "R1 memWe low", int'(memWe), 0);
    check(irq == 1'b0, "R1 irq low", int'(irq), 0);
    check(adcSingleShot == 1'b0, "R1 count field zero", int'(adcSingleShot), 0);
    clearLog();
    pulseReq();
    repeat (20) @(negedge clk);
    check(nStart == 0 && nWr == 0, "R1 enable zero after reset", nStart + nWr, 0);

    // R2: disabled with a non-zero count, request ignored
    writeReg(1'b0, 8'h2A);
    writeReg(1'b1, (5 << 2) | 2);
    clearLog();
    pulseReq();
    repeat (40) @(negedge clk);
    check(nStart == 0, "R2 no start while disabled", nStart, 0);
    check(nWr == 0, "R2 no write while disabled", nWr, 0);
    check(nIrq == 0, "R2 no irq while disabled", nIrq, 0);

    // R3 R4 R6 R7 R8 R10 R11: sweep count, irq enable, base
    for (int b = 0; b < 3; b++) begin
      int base = (b == 0) ? 0 : (b == 1) ? 8'h55 : 8'h7F;
      for (int c = 0; c < 8; c++)
        for (int ie = 0; ie < 2; ie++)
          runScan(base, c, ie, b * 16 + c * 2 + ie);
    end

    // R9: abort while the lower byte of input 1 is being written
    seed = 3;
    writeReg(1'b0, 8'h11);
    writeReg(1'b1, (7 << 2) | 2 | 1);
    clearLog();
    pulseReq();
    for (int t = 0; t < 200 && nWr < 3; t++) @(negedge clk);
    regWe = 1'b1; regSel = 1'b1; regWdata = 8'((7 << 2) | 2);
    @(negedge clk);
    regWe = 1'b0;
    repeat (60) @(negedge clk);
    check(nWr == 4, "R9 pair completes then stops", nWr, 4);
    check(nStart == 2, "R9 no further start", nStart, 2);
    check(nIrq == 0, "R9 no irq on abort", nIrq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule